// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit builds 20-bit physical byte addresses out of 16-bit segment bases and 16-bit offsets. It keeps four segment base registers (code, data, stack, extra), each holding the upper 16 bits of a segment's 20-bit start address. The physical address is the base shifted left by four bits plus the zero-extended offset, kept to 20 bits, so it wraps past the top of the 1,048,576-byte space.

Each request names an offset source: the instruction pointer, the stack pointer, the base pointer or a general offset. The source picks a default segment. Instruction fetches always use the code segment and stack pointer accesses always use the stack segment. Base pointer and general accesses default to the stack and data segments, and a segment override can redirect them. Requests arrive on a valid/ready input and leave through a one-entry registered valid/ready output. A request is taken on any edge where `req_valid` and `req_ready` are both high. The output holds address and valid until `out_ready` takes it, and `req_ready` is low only while a result is waiting and not being taken. A separate plain load port writes the segment registers.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset `out_valid` is 0, `req_ready` is 1 and all four segment registers are zero.
- R2: The address is (segment × 16 + offset) modulo 2^20, so a sum above 0xFFFFF wraps to the bottom of memory.
- R3: Offset source 00 (instruction pointer, `ip_in`) always uses the code segment; the override is ignored.
- R4: Offset source 01 (stack pointer, `sp_in`) always uses the stack segment; the override is ignored.
- R5: Offset source 10 (base pointer, `bp_in`) uses the stack segment, or the segment in `req_seg` when `req_ovr` is 1.
- R6: Offset source 11 (general, `gen_off`) uses the data segment, or the segment in `req_seg` when `req_ovr` is 1.
- R7: Segment numbers on `seg_wr_sel` and `req_seg` are 00 extra, 01 code, 10 stack, 11 data.
- R8: A segment write is stored at the clock edge on which `seg_wr_en` is high. A request accepted at that same edge still uses the old value, and requests accepted at later edges use the new one.
- R9: A request accepted at an edge shows its address with `out_valid` high from that edge on, one register stage.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_addr` and `out_valid` hold steady.
- R11: `req_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0, so with a steady sink one request passes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write (R7 encoding) |
| seg_wr_data | input | 16 | New segment base |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_src | input | 2 | Offset source: 00 IP, 01 SP, 10 BP, 11 general |
| req_ovr | input | 1 | Segment override enable |
| req_seg | input | 2 | Override segment (R7 encoding) |
| ip_in | input | 16 | Instruction pointer |
| sp_in | input | 16 | Stack pointer |
| bp_in | input | 16 | Base pointer |
| gen_off | input | 16 | General offset |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Downstream takes the address |
| out_addr | output | 20 | Physical address |

## Verification
Every address becomes visible one edge after its request is accepted. A second edge passes before it leaves if `out_ready` is low. A segment write counts for requests accepted from the following edge on. Requests are driven half a cycle before the edge, and each expected address is queued at the moment of acceptance, computed from a bench model of the segment registers as they were before that edge. The monitor compares an address only in a cycle where `out_valid` and `out_ready` are both high at mid-cycle, so the checks follow the handshake rather than a fixed latency, even while the sink stalls on a repeating pattern.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_id_t;

  typedef enum logic [1:0] {
    OSRC_IP  = 2'b00,
    OSRC_SP  = 2'b01,
    OSRC_BP  = 2'b10,
    OSRC_GEN = 2'b11
  } osrc_t;

  localparam int NUM_SEGS = 4;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [SEG_W-1:0]           wr_data,
  output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_q[i] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(i))) begin
        seg_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/seg_route.sv
module seg_route
  import seg_addr_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  osrc_t            src,
  input  logic             ovr,
  input  seg_id_t          ovr_seg,
  input  logic [OFF_W-1:0] ip,
  input  logic [OFF_W-1:0] sp,
  input  logic [OFF_W-1:0] bp,
  input  logic [OFF_W-1:0] gen,
  output seg_id_t          seg_pick,
  output logic [OFF_W-1:0] off_pick
);
  always_comb begin
    unique case (src)
      OSRC_IP: begin
        seg_pick = SEG_CODE;
        off_pick = ip;
      end
      OSRC_SP: begin
        seg_pick = SEG_STACK;
        off_pick = sp;
      end
      OSRC_BP: begin
        seg_pick = ovr ? ovr_seg : SEG_STACK;
        off_pick = bp;
      end
      default: begin
        seg_pick = ovr ? ovr_seg : SEG_DATA;
        off_pick = gen;
      end
    endcase
  end
endmodule

// File: rtl/seg_linear.sv
module seg_linear #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] off_ext;

  always_comb begin
    base_ext = {seg, {SHIFT{1'b0}}};
    off_ext  = {{(PA_W-OFF_W){1'b0}}, off};
    addr     = base_ext + off_ext;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [1:0]       seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_src,
  input  logic             req_ovr,
  input  logic [1:0]       req_seg,
  input  logic [OFF_W-1:0] ip_in,
  input  logic [OFF_W-1:0] sp_in,
  input  logic [OFF_W-1:0] bp_in,
  input  logic [OFF_W-1:0] gen_off,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PA_W-1:0]  out_addr
);
  logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
  seg_id_t          seg_pick;
  logic [OFF_W-1:0] off_pick;
  logic [PA_W-1:0]  lin_addr;
  logic             take;

  seg_bank #(.SEG_W(SEG_W), .NSEG(NUM_SEGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .seg_q   (seg_q)
  );

  seg_route #(.OFF_W(OFF_W)) u_route (
    .src      (osrc_t'(req_src)),
    .ovr      (req_ovr),
    .ovr_seg  (seg_id_t'(req_seg)),
    .ip       (ip_in),
    .sp       (sp_in),
    .bp       (bp_in),
    .gen      (gen_off),
    .seg_pick (seg_pick),
    .off_pick (off_pick)
  );

  seg_linear #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_lin (
    .seg  (seg_q[seg_pick]),
    .off  (off_pick),
    .addr (lin_addr)
  );

  assign req_ready = !out_valid || out_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_addr  <= lin_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [1:0]             req_src,
  input logic                   req_ovr,
  input logic [OFF_W-1:0]       ip_in,
  input logic [OFF_W-1:0]       sp_in,
  input logic [OFF_W-1:0]       bp_in,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [PA_W-1:0]        out_addr,
  input logic [3:0][SEG_W-1:0]  seg_now
);
  // R10: stalled output keeps its value
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R11: no acceptance while a result waits
  a_r11_block_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !req_ready);

  // R9: accepted request is presented on the next cycle
  a_r9_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);

  // R3: instruction fetch uses the code segment
  a_r3_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_src == 2'b00) |=>
    (out_addr == ({$past(seg_now[1]), {SHIFT{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, $past(ip_in)})));

  // R4: stack pointer uses the stack segment
  a_r4_sp_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_src == 2'b01) |=>
    (out_addr == ({$past(seg_now[2]), {SHIFT{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, $past(sp_in)})));

  // R5: base pointer without override uses the stack segment
  a_r5_bp_default: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_src == 2'b10 && !req_ovr) |=>
    (out_addr == ({$past(seg_now[2]), {SHIFT{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, $past(bp_in)})));
endmodule

bind seg_addr_gen seg_addr_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_src   (req_src),
  .req_ovr   (req_ovr),
  .ip_in     (ip_in),
  .sp_in     (sp_in),
  .bp_in     (bp_in),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .seg_now   (seg_q)
);

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_src = '0;
  logic        req_ovr = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [15:0] ip_in = '0, sp_in = '0, bp_in = '0, gen_off = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_addr;

  int checks = 0;
  int fails = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  logic [15:0] model [4];
  logic [19:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  seg_addr_gen dut (.*);

  task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] calc(input logic [1:0] src, input logic ovr,
                                       input logic [1:0] sel, input logic [15:0] off);
    logic [1:0] s;
    case (src)
      2'b00: s = 2'b01;
      2'b01: s = 2'b10;
      2'b10: s = ovr ? sel : 2'b10;
      default: s = ovr ? sel : 2'b11;
    endcase
    return {model[s], 4'h0} + {4'h0, off};
  endfunction

  // driver: sends one request (optionally with a segment write in the same cycle)
  task automatic send(input logic [1:0] src, input logic ovr, input logic [1:0] sel,
                      input logic [15:0] off, input bit wr, input logic [1:0] wsel,
                      input logic [15:0] wdata, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_src = src; req_ovr = ovr; req_seg = sel;
    ip_in  = (src == 2'b00) ? off : off ^ 16'h0A0A;
    sp_in  = (src == 2'b01) ? off : off ^ 16'h0B0B;
    bp_in  = (src == 2'b10) ? off : off ^ 16'h0C0C;
    gen_off = (src == 2'b11) ? off : off ^ 16'h0D0D;
    seg_wr_en = wr; seg_wr_sel = wsel; seg_wr_data = wdata;
    #1;
    forever begin
      // R11: ready low exactly when a result waits unread
      chk(req_ready == !(out_valid && !out_ready), "R11 req_ready",
          {19'd0, req_ready}, {19'd0, !(out_valid && !out_ready)});
      if (req_ready) break;
      @(negedge clk); #1;
    end
    exp_q.push_back(calc(src, ovr, sel, off));
    tag_q.push_back(tag);
    @(posedge clk);
    if (wr) model[wsel] = wdata;
  endtask

  task automatic seg_write(input logic [1:0] wsel, input logic [15:0] wdata);
    @(negedge clk);
    req_valid = 1'b0;
    seg_wr_en = 1'b1; seg_wr_sel = wsel; seg_wr_data = wdata;
    @(posedge clk);
    model[wsel] = wdata;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; seg_wr_en = 1'b0;
  endtask

  // monitor: drives the sink ready and compares delivered addresses
  initial begin
    int cyc = 0;
    bit held = 1'b0;
    logic [19:0] held_addr = '0;
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      #1;
      if (rst_n) begin
        if (held) begin
          chk(out_valid && out_addr == held_addr, "R10 hold while stalled", out_addr, held_addr);
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected output", out_addr, 20'h0);
          end else begin
            logic [19:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_addr == e, t, out_addr, e);
          end
        end
        held = out_valid && !out_ready;
        held_addr = out_addr;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", {19'd0, out_valid}, 20'd0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", {19'd0, req_ready}, 20'd1);
    send(2'b00, 1'b0, 2'b00, 16'h1234, 1'b0, 2'b00, 16'h0, "R1 zero segments fetch");
    send(2'b11, 1'b0, 2'b00, 16'h4321, 1'b0, 2'b00, 16'h0, "R1 zero data segment");
    idle();
    // R7: write each segment by its number
    seg_write(2'b00, 16'h4000);
    seg_write(2'b01, 16'h1000);
    seg_write(2'b10, 16'h2000);
    seg_write(2'b11, 16'h3000);
    idle();
    send(2'b00, 1'b1, 2'b00, 16'h0010, 1'b0, 2'b00, 16'h0, "R3 fetch ignores override");
    send(2'b01, 1'b1, 2'b11, 16'h0100, 1'b0, 2'b00, 16'h0, "R4 sp ignores override");
    send(2'b10, 1'b0, 2'b00, 16'h0200, 1'b0, 2'b00, 16'h0, "R5 bp default stack");
    send(2'b10, 1'b1, 2'b00, 16'h0200, 1'b0, 2'b00, 16'h0, "R5 bp override extra");
    send(2'b11, 1'b0, 2'b00, 16'h0300, 1'b0, 2'b00, 16'h0, "R6 general default data");
    send(2'b11, 1'b1, 2'b01, 16'h0300, 1'b0, 2'b00, 16'h0, "R6 R7 general override code");
    send(2'b10, 1'b1, 2'b11, 16'h0040, 1'b0, 2'b00, 16'h0, "R7 bp override data");
    idle();
    seg_write(2'b11, 16'hFFFF);
    send(2'b11, 1'b0, 2'b00, 16'h0020, 1'b0, 2'b00, 16'h0, "R2 wrap past top");
    send(2'b11, 1'b0, 2'b00, 16'h000F, 1'b0, 2'b00, 16'h0, "R2 top byte");
    // R8: write and request in the same cycle
    send(2'b00, 1'b0, 2'b00, 16'h0000, 1'b1, 2'b01, 16'h5000, "R8 same-cycle old value");
    send(2'b00, 1'b0, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0, "R8 next-cycle new value");
    idle();
    // R9 R10 R11: burst under back-pressure
    stall_mode = 1'b1;
    for (int k = 0; k < 24; k++) begin
      send(2'(k), k[2], 2'(k >> 1), 16'(k * 16'h0731), 1'b0, 2'b00, 16'h0, "R9 R10 burst");
    end
    idle();
    repeat (10) @(posedge clk);
    stall_mode = 1'b0;
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R9 all results delivered", 20'(exp_q.size()), 20'd0);
    finish_run();
  end
endmodule